// File: doc/BRIEF.md
# Serial NOR Flash Command Guard

This block is the command front end of a serial NOR flash slave. It oversamples SPI mode 0 traffic on a fast system clock, frames it with an active-low chip select and treats the first byte of each frame as the opcode. It holds the status register: write in progress, write enable latch, three block-protect bits and a status-lock bit. Software reads this register back through the serial port.

Every instruction that changes data or status is decided when chip select rises. The instruction passes a series of gates: the frame must hold whole bytes and enough of them, the write enable latch must be set, the device must not be busy or asleep, the target sector must not be protected, and the status lock must allow the write. Only an instruction that passes all of them raises a one-cycle execute pulse to the array side. A short fixed busy counter stands in for real program and erase time. A deep power-down state ignores every opcode except the wake-up opcode, and an input pulse stands in for power-up.

Top module: `flash_cmd_guard`

## Requirements
- R1: After `rstN` is released the status byte reads 00h and no execute pulse occurs.
- R2: Opcode 05h returns the status byte MSB first after the opcode and repeats it in every further byte. Bit0 is write in progress, bit1 is the write enable latch, bits 4:2 are the block-protect value, bit7 is the status lock and bits 6:5 read as zero.
- R3: Opcode 06h sets the write enable latch and opcode 04h clears it. Each takes effect at the rising edge of chip select.
- R4: Opcodes 01h (status write), 02h (program), D8h (sector erase) and C7h (bulk erase) are ignored when the write enable latch is clear.
- R5: A write-class frame whose count of SCK rising edges is not a multiple of eight is discarded, and the latch keeps its value.
- R6: An accepted write-class frame gives one `execValid` cycle. `execKind` is 0 for program, 1 for sector erase, 2 for bulk erase and 3 for status write, and `execAddr` carries the 24-bit address. Write in progress is then set for `BUSY_CYCLES` clocks, and when it drops the write enable latch clears as well.
- R7: While write in progress is set, only opcode 05h has an effect.
- R8: With block-protect value 1, 2 or 3, the top 1, 2 or 4 of the eight 64 KB sectors (address bits 18:16) are read-only, and values 4 to 7 protect all eight. Program or sector erase aimed at a protected sector is refused. Bulk erase is refused whenever the value is nonzero.
- R9: When the status lock bit is 1 and `wpNIn` is low, a status write is refused and the latch stays set. When `wpNIn` is high the write is accepted and stores data bits 7 and 4:2.
- R10: Opcode B9h enters power-down. In that state every opcode except ABh is ignored, including status read, whose output stays low. Opcode ABh leaves the state.
- R11: A `powerUp` pulse clears the latch and write in progress and leaves power-down, while the block-protect and lock bits keep their values.
- R12: A status write needs at least 2 bytes, a program at least 5 and a sector erase at least 4. Shorter frames are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCK |
| rstN | input | 1 | Asynchronous active-low reset |
| powerUp | input | 1 | One-cycle power-up event |
| sckIn | input | 1 | Serial clock, asynchronous |
| csNIn | input | 1 | Active-low chip select, asynchronous |
| mosiIn | input | 1 | Serial data in |
| wpNIn | input | 1 | Active-low write-protect pin |
| misoOut | output | 1 | Serial data out (status read) |
| execValid | output | 1 | One-cycle pulse for an accepted write-class instruction |
| execKind | output | 2 | 0 program, 1 sector erase, 2 bulk erase, 3 status write |
| execAddr | output | 24 | Address of the accepted instruction (0 for bulk and status) |

## Verification
Directed frames cover each gate on its own: a latch-clear erase, frames with extra or missing bits, frames that are too short, opcodes sent while busy or asleep, a locked status write with the pin low and then high, and a bulk erase under protection. Each case changes a single gate, so a failure points at that gate and not at another. Random program and erase addresses are then tried against random block-protect values. This shows whether the sector thresholds are placed exactly, because the latch value that reads back tells an accepted instruction apart from a refused one.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_SERA = 8'hD8;
  localparam logic [7:0] OP_BERA = 8'hC7;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WAKE = 8'hAB;

  localparam int SPI_AW    = 24;
  localparam int SECT_BITS = 3;

  typedef enum logic [1:0] {
    EX_PROG  = 2'd0,
    EX_SECT  = 2'd1,
    EX_BULK  = 2'd2,
    EX_WSTAT = 2'd3
  } execKind_e;

  typedef struct packed {
    logic pwrClr;
    logic welSet;
    logic welClr;
    logic statWrite;
    logic wipSet;
    logic wipDone;
  } guardStrobe_t;

  // protected region grows from the top sector downward
  function automatic logic sectorLocked(input logic [2:0] bp,
                                        input logic [SECT_BITS-1:0] sect);
    logic res;
    case (bp)
      3'd0:    res = 1'b0;
      3'd1:    res = (sect == '1);
      3'd2:    res = (sect[SECT_BITS-1:1] == '1);
      3'd3:    res = (sect[SECT_BITS-1:2] == '1);
      default: res = 1'b1;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/flash_guard_dp.sv
module flash_guard_dp
  import flash_guard_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csNIn,
  input  logic              mosiIn,
  input  logic              wpNIn,
  input  guardStrobe_t      stb,
  input  logic              pdQ,
  output logic              csRise,
  output logic [2:0]        bitPos,
  output logic [2:0]        byteCnt,
  output logic [7:0]        opcode,
  output logic [SPI_AW-1:0] addrQ,
  output logic              wipQ,
  output logic              welQ,
  output logic              srwdQ,
  output logic [2:0]        bpQ,
  output logic              wpLow,
  output logic              misoOut
);

  localparam int NIN = 4;
  // idle levels: wp high, mosi low, cs high, sck low
  localparam logic [NIN-1:0] IDLE_LEVEL = 4'b1010;

  logic [NIN-1:0] rawIn;
  logic [NIN-1:0] syncOut;
  assign rawIn = {wpNIn, mosiIn, csNIn, sckIn};

  for (genvar g = 0; g < NIN; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {SYNC_STAGES{IDLE_LEVEL[g]}};
      else       chain <= {chain[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign syncOut[g] = chain[SYNC_STAGES-1];
  end

  logic sckS, csS, mosiS, wpS;
  assign sckS  = syncOut[0];
  assign csS   = syncOut[1];
  assign mosiS = syncOut[2];
  assign wpS   = syncOut[3];
  assign wpLow = ~wpS;

  logic sckPrev, csPrev;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      csPrev  <= 1'b1;
    end else begin
      sckPrev <= sckS;
      csPrev  <= csS;
    end
  end

  logic sckRise, sckFall;
  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;
  assign csRise  = csS & ~csPrev;

  // frame capture
  logic [6:0] shiftReg;
  logic [7:0] nextByte;
  logic [7:0] addrHi, addrMid, addrLo;
  assign nextByte = {shiftReg, mosiS};
  assign addrQ    = {addrHi, addrMid, addrLo};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitPos   <= '0;
      byteCnt  <= '0;
      opcode   <= '0;
      addrHi   <= '0;
      addrMid  <= '0;
      addrLo   <= '0;
    end else if (csS) begin
      bitPos  <= '0;
      byteCnt <= '0;
    end else if (sckRise) begin
      shiftReg <= nextByte[6:0];
      bitPos   <= bitPos + 3'd1;
      if (bitPos == 3'd7) begin
        if (byteCnt != 3'd7) byteCnt <= byteCnt + 3'd1;
        case (byteCnt)
          3'd0:    opcode  <= nextByte;
          3'd1:    addrHi  <= nextByte;
          3'd2:    addrMid <= nextByte;
          3'd3:    addrLo  <= nextByte;
          default: ;
        endcase
      end
    end
  end

  // status register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wipQ  <= 1'b0;
      welQ  <= 1'b0;
      srwdQ <= 1'b0;
      bpQ   <= '0;
    end else if (stb.pwrClr) begin
      wipQ <= 1'b0;
      welQ <= 1'b0;
    end else begin
      if (stb.welSet) welQ <= 1'b1;
      if (stb.welClr) welQ <= 1'b0;
      if (stb.statWrite) begin
        bpQ   <= addrHi[4:2];
        srwdQ <= addrHi[7];
      end
      if (stb.wipSet) wipQ <= 1'b1;
      if (stb.wipDone) begin
        wipQ <= 1'b0;
        welQ <= 1'b0;
      end
    end
  end

  logic [7:0] statusByte;
  assign statusByte = {srwdQ, 2'b00, bpQ, welQ, wipQ};

  // status read-out, changes on SCK falling edges
  logic [7:0] outReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else if (!csS && sckFall) begin
      if (bitPos == 3'd0 && byteCnt != 3'd0) outReg <= statusByte;
      else                                   outReg <= {outReg[6:0], 1'b0};
    end
  end

  logic rdActive;
  assign rdActive = !csS && !pdQ && (byteCnt != 3'd0) && (opcode == OP_RDSR);
  assign misoOut  = rdActive & outReg[7];

endmodule

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
  import flash_guard_pkg::*;
#(
  parameter int ARRAY_AW    = 19,
  parameter int BUSY_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerUp,
  input  logic              csRise,
  input  logic [2:0]        bitPos,
  input  logic [2:0]        byteCnt,
  input  logic [7:0]        opcode,
  input  logic [SPI_AW-1:0] addrQ,
  input  logic              wipQ,
  input  logic              welQ,
  input  logic              srwdQ,
  input  logic [2:0]        bpQ,
  input  logic              wpLow,
  output guardStrobe_t      stb,
  output logic              execValid,
  output logic [1:0]        execKind,
  output logic [SPI_AW-1:0] execAddr,
  output logic              pdQ
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] BUSY_LOAD = CNT_W'(BUSY_CYCLES);

  logic [CNT_W-1:0] busyCnt;
  logic             wholeBytes, locked, canWrite;

  assign wholeBytes = (bitPos == 3'd0);
  assign locked     = sectorLocked(bpQ, addrQ[ARRAY_AW-1 -: SECT_BITS]);
  assign canWrite   = wholeBytes && welQ;

  guardStrobe_t      nxtStb;
  logic              nxtExec, nxtPd;
  execKind_e         nxtKind;
  logic [SPI_AW-1:0] nxtAddr;

  always_comb begin
    nxtStb  = '0;
    nxtExec = 1'b0;
    nxtKind = EX_PROG;
    nxtAddr = '0;
    nxtPd   = pdQ;
    if (csRise && byteCnt != 3'd0) begin
      if (pdQ) begin
        if (opcode == OP_WAKE) nxtPd = 1'b0;
      end else if (!wipQ) begin
        case (opcode)
          OP_WREN:  nxtStb.welSet = 1'b1;
          OP_WRDI:  nxtStb.welClr = 1'b1;
          OP_SLEEP: nxtPd = 1'b1;
          OP_WRSR: begin
            if (canWrite && byteCnt >= 3'd2 && !(srwdQ && wpLow)) begin
              nxtExec          = 1'b1;
              nxtKind          = EX_WSTAT;
              nxtStb.statWrite = 1'b1;
              nxtStb.wipSet    = 1'b1;
            end
          end
          OP_PROG: begin
            if (canWrite && byteCnt >= 3'd5 && !locked) begin
              nxtExec       = 1'b1;
              nxtKind       = EX_PROG;
              nxtAddr       = addrQ;
              nxtStb.wipSet = 1'b1;
            end
          end
          OP_SERA: begin
            if (canWrite && byteCnt >= 3'd4 && !locked) begin
              nxtExec       = 1'b1;
              nxtKind       = EX_SECT;
              nxtAddr       = addrQ;
              nxtStb.wipSet = 1'b1;
            end
          end
          OP_BERA: begin
            if (canWrite && bpQ == 3'd0) begin
              nxtExec       = 1'b1;
              nxtKind       = EX_BULK;
              nxtStb.wipSet = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
    if (busyCnt == CNT_W'(1)) nxtStb.wipDone = 1'b1;
    if (powerUp) begin
      nxtStb        = '0;
      nxtStb.pwrClr = 1'b1;
      nxtExec       = 1'b0;
      nxtPd         = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stb       <= '0;
      execValid <= 1'b0;
      execKind  <= '0;
      execAddr  <= '0;
      pdQ       <= 1'b0;
      busyCnt   <= '0;
    end else begin
      stb       <= nxtStb;
      execValid <= nxtExec;
      execKind  <= nxtKind;
      execAddr  <= nxtAddr;
      pdQ       <= nxtPd;
      if (powerUp)              busyCnt <= '0;
      else if (nxtExec)         busyCnt <= BUSY_LOAD;
      else if (busyCnt != '0)   busyCnt <= busyCnt - CNT_W'(1);
    end
  end

endmodule

// File: rtl/flash_cmd_guard.sv
module flash_cmd_guard
  import flash_guard_pkg::*;
#(
  parameter int ARRAY_AW    = 19,
  parameter int BUSY_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerUp,
  input  logic              sckIn,
  input  logic              csNIn,
  input  logic              mosiIn,
  input  logic              wpNIn,
  output logic              misoOut,
  output logic              execValid,
  output logic [1:0]        execKind,
  output logic [SPI_AW-1:0] execAddr
);

  guardStrobe_t      stb;
  logic              csRise, wipQ, welQ, srwdQ, wpLow, pdQ;
  logic [2:0]        bitPos, byteCnt, bpQ;
  logic [7:0]        opcode;
  logic [SPI_AW-1:0] addrQ;

  flash_guard_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN),
    .sckIn(sckIn), .csNIn(csNIn), .mosiIn(mosiIn), .wpNIn(wpNIn),
    .stb(stb), .pdQ(pdQ),
    .csRise(csRise), .bitPos(bitPos), .byteCnt(byteCnt), .opcode(opcode),
    .addrQ(addrQ), .wipQ(wipQ), .welQ(welQ), .srwdQ(srwdQ), .bpQ(bpQ),
    .wpLow(wpLow), .misoOut(misoOut)
  );

  flash_guard_ctrl #(.ARRAY_AW(ARRAY_AW), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .powerUp(powerUp),
    .csRise(csRise), .bitPos(bitPos), .byteCnt(byteCnt), .opcode(opcode),
    .addrQ(addrQ), .wipQ(wipQ), .welQ(welQ), .srwdQ(srwdQ), .bpQ(bpQ),
    .wpLow(wpLow), .stb(stb), .execValid(execValid), .execKind(execKind),
    .execAddr(execAddr), .pdQ(pdQ)
  );

endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk
  import flash_guard_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       execValid,
  input logic [1:0] execKind,
  input logic       wipQ,
  input logic       welQ,
  input logic       pdQ,
  input logic       misoOut,
  input logic [2:0] bpQ
);

  a_r6_exec_single: assert property (@(posedge clk) disable iff (!rstN)
    execValid |=> !execValid);

  a_r6_wip_follows: assert property (@(posedge clk) disable iff (!rstN)
    execValid |=> wipQ);

  a_r4_exec_needs_wel: assert property (@(posedge clk) disable iff (!rstN)
    execValid |-> $past(welQ));

  a_r7_exec_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    execValid |-> !$past(wipQ));

  a_r10_exec_not_asleep: assert property (@(posedge clk) disable iff (!rstN)
    execValid |-> !$past(pdQ));

  a_r10_asleep_quiet: assert property (@(posedge clk) disable iff (!rstN)
    pdQ |-> !misoOut);

  a_r8_bulk_unprotected: assert property (@(posedge clk) disable iff (!rstN)
    (execValid && execKind == EX_BULK) |-> ($past(bpQ) == 3'd0));

endmodule

bind flash_cmd_guard flash_guard_chk u_chk (
  .clk(clk), .rstN(rstN), .execValid(execValid), .execKind(execKind),
  .wipQ(wipQ), .welQ(welQ), .pdQ(pdQ), .misoOut(misoOut), .bpQ(bpQ)
);

// File: tb/flash_cmd_guard_bench.sv
module flash_cmd_guard_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 1500;
  localparam int HALF       = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerUp = 1'b0;
  logic sck = 1'b0, csN = 1'b1, mosi = 1'b0, wpN = 1'b1;
  logic miso, execValid;
  logic [1:0] execKind;
  logic [23:0] execAddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_guard #(.BUSY_CYCLES(BUSY)) u_flash_cmd_guard (
    .clk(clk), .rstN(rstN), .powerUp(powerUp), .sckIn(sck), .csNIn(csN),
    .mosiIn(mosi), .wpNIn(wpN), .misoOut(miso), .execValid(execValid),
    .execKind(execKind), .execAddr(execAddr)
  );

  int checks = 0;
  int errors = 0;
  int execCnt = 0;
  logic [1:0]  lastKind = '0;
  logic [23:0] lastAddr = '0;
  logic [7:0] txBuf [8];
  logic [7:0] rxBuf [8];
  logic [7:0] st;

  always @(negedge clk) if (execValid) begin
    execCnt++;
    lastKind = execKind;
    lastAddr = execAddr;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic spiFrame(input int nBits);
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      mosi = txBuf[i/8][7-(i%8)];
      repeat (HALF) @(negedge clk);
      rxBuf[i/8][7-(i%8)] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    txBuf[0] = op;
    spiFrame(8);
  endtask

  task automatic readStatus(output logic [7:0] s);
    txBuf[0] = 8'h05;
    spiFrame(16);
    s = rxBuf[1];
  endtask

  task automatic wrStatus(input logic [7:0] v);
    txBuf[0] = 8'h01;
    txBuf[1] = v;
    spiFrame(16);
  endtask

  task automatic addrCmd(input logic [7:0] op, input logic [23:0] a, input int nBits);
    txBuf[0] = op;
    txBuf[1] = a[23:16];
    txBuf[2] = a[15:8];
    txBuf[3] = a[7:0];
    txBuf[4] = 8'hA5;
    txBuf[5] = 8'h3C;
    spiFrame(nBits);
  endtask

  task automatic waitBusy();
    repeat (BUSY + 100) @(negedge clk);
  endtask

  function automatic bit isLocked(input int bp, input int sect);
    if (bp == 0) return 0;
    if (bp == 1) return sect == 7;
    if (bp == 2) return sect >= 6;
    if (bp == 3) return sect >= 4;
    return 1;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) txBuf[i] = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R1, R2 reset state
    readStatus(st);
    check("R1 status after reset", st, 8'h00);
    check("R1 no exec after reset", execCnt, 0);

    // R3 latch set and clear
    cmd1(8'h06); readStatus(st); check("R3 WEL set", st, 8'h02);
    cmd1(8'h04); readStatus(st); check("R3 WEL clear", st, 8'h00);

    // R4 erase without latch
    addrCmd(8'hD8, 24'h010000, 32);
    check("R4 no exec without WEL", execCnt, 0);

    // R5 partial bytes
    cmd1(8'h06);
    addrCmd(8'hD8, 24'h010000, 32 + 1 + ($urandom % 7));
    check("R5 ragged frame no exec", execCnt, 0);
    readStatus(st); check("R5 WEL kept", st, 8'h02);

    // R12 short sector erase and short program
    addrCmd(8'hD8, 24'h010000, 24);
    check("R12 short erase no exec", execCnt, 0);
    addrCmd(8'h02, 24'h010000, 32);
    check("R12 short program no exec", execCnt, 0);

    // R6 accepted erase
    addrCmd(8'hD8, 24'h012345, 32);
    check("R6 exec count", execCnt, 1);
    check("R6 exec kind", lastKind, 1);
    check("R6 exec addr", lastAddr, 24'h012345);
    readStatus(st); check("R6 WIP set", st, 8'h03);
    // R7 write disable ignored while busy
    cmd1(8'h04); cmd1(8'h06);
    readStatus(st); check("R7 busy ignores WRDI", st, 8'h03);
    addrCmd(8'hD8, 24'h020000, 32);
    check("R7 busy ignores erase", execCnt, 1);
    waitBusy();
    readStatus(st); check("R6 WIP and WEL clear", st, 8'h00);

    // R2 field layout and repetition
    cmd1(8'h06); wrStatus(8'hFF);
    check("R6 status write kind", lastKind, 3);
    waitBusy();
    txBuf[0] = 8'h05; spiFrame(32);
    check("R2 status byte", rxBuf[1], 8'h9C);
    check("R2 status repeats", rxBuf[3], 8'h9C);

    // R9 lock with pin
    wpN = 1'b0;
    cmd1(8'h06); base = execCnt;
    wrStatus(8'h00);
    check("R9 locked write refused", execCnt, base);
    readStatus(st); check("R9 status unchanged", st, 8'h9E);
    wpN = 1'b1;
    wrStatus(8'h00);
    check("R9 unlocked write accepted", execCnt, base + 1);
    waitBusy();
    readStatus(st); check("R9 status written", st, 8'h00);

    // R8 bulk erase under protection
    cmd1(8'h06); wrStatus(8'h04); waitBusy();
    cmd1(8'h06); base = execCnt;
    addrCmd(8'hC7, 24'h0, 8);
    check("R8 bulk refused", execCnt, base);
    wrStatus(8'h00); waitBusy();
    cmd1(8'h06); addrCmd(8'hC7, 24'h0, 8);
    check("R8 bulk accepted", execCnt, base + 2);
    check("R6 bulk kind", lastKind, 2);
    waitBusy();

    // R6 program with 5 bytes
    cmd1(8'h06); addrCmd(8'h02, 24'h07FFFF, 40);
    check("R6 program kind", lastKind, 0);
    check("R6 program addr", lastAddr, 24'h07FFFF);
    waitBusy();

    // R10 power-down
    cmd1(8'h06); cmd1(8'hB9);
    readStatus(st); check("R10 read silent asleep", st, 8'h00);
    cmd1(8'h04); base = execCnt;
    addrCmd(8'hD8, 24'h0, 32);
    check("R10 erase ignored asleep", execCnt, base);
    cmd1(8'hAB);
    readStatus(st); check("R10 WRDI ignored, woke", st, 8'h02);

    // R11 power-up pulse
    wrStatus(8'h08); waitBusy();
    cmd1(8'h06); cmd1(8'hB9);
    @(negedge clk); powerUp = 1'b1; @(negedge clk); powerUp = 1'b0;
    repeat (4) @(negedge clk);
    readStatus(st); check("R11 WEL cleared, BP kept", st, 8'h08);
    cmd1(8'h06); wrStatus(8'h08);
    @(negedge clk); powerUp = 1'b1; @(negedge clk); powerUp = 1'b0;
    repeat (4) @(negedge clk);
    readStatus(st); check("R11 busy cancelled", st, 8'h08);

    // R8 random sector protection
    for (int it = 0; it < 12; it++) begin
      int bp, sect, isSe;
      logic [23:0] a;
      bit exp;
      bp   = $urandom % 8;
      sect = $urandom % 8;
      isSe = $urandom % 2;
      a = {5'd0, sect[2:0], 16'($urandom)};
      cmd1(8'h06); wrStatus({3'b000, bp[2:0], 2'b00}); waitBusy();
      cmd1(8'h06); base = execCnt;
      if (isSe != 0) addrCmd(8'hD8, a, 32);
      else           addrCmd(8'h02, a, 48);
      exp = !isLocked(bp, sect);
      check("R8 protect decision", execCnt - base, exp ? 1 : 0);
      if (exp) waitBusy();
      readStatus(st);
      check("R8 status after attempt", st, {3'b000, bp[2:0], 1'b0 ^ !exp, 1'b0});
      cmd1(8'h04);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule